// File: doc/BRIEF.md
# SIMD Lane-Pair Transpose Unit

This unit takes two vector operands, A and B, and treats each pair of adjacent lanes taken across both operands as a 2x2 matrix. It transposes every such matrix. For each pair index, the odd lane of A trades places with the even lane of B. The even lanes of A and the odd lanes of B keep their positions. Lane width is 8, 16 or 32 bits, set by a 2-bit size code. Operands are 64 or 128 bits wide, set by a quad flag. In quad mode the two 64-bit halves are handled separately, and no lane crosses the 64-bit boundary.

The unit also checks the encoding fields that come with the operation. A reserved size code, or an odd register index in quad mode, makes the operation illegal. Equal register indices make it a same-register case. Every result is registered with a fixed one-cycle latency that does not depend on the data. A rejected or same-register operation still completes with out_valid, and both result buses are zero.

Top module: `lane_transpose`

## Requirements
- R1: After reset, out_valid, illegal and same_reg are 0 and both result buses are zero.
- R2: Every in_valid produces out_valid exactly one cycle later. Without in_valid, out_valid is 0 on the next cycle.
- R3: Size code 0 gives 8-bit lanes, 1 gives 16-bit lanes and 2 gives 32-bit lanes. For a lane pair index e, res_a lane 2e+1 is B's original lane 2e, and res_b lane 2e is A's original lane 2e+1. Lane 0 occupies the least significant bits.
- R4: res_a even lanes equal A's even lanes, and res_b odd lanes equal B's odd lanes.
- R5: Size code 3 sets illegal and zeroes both results.
- R6: With quad set, a 1 in bit 0 of either register index sets illegal and zeroes both results.
- R7: With quad set, bits 127:64 are transposed on their own with the same lane rule. No lane moves across bit 64.
- R8: With quad clear, bits 127:64 of both results are zero.
- R9: Equal register indices on a legal operation set same_reg and zero both results. On an illegal operation, same_reg stays 0.
- R10: An accepted operation with illegal set still raises out_valid. Data-path flags and results update only when in_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| size_code | input | 2 | Lane width select |
| quad | input | 1 | 128-bit operation when 1 |
| idx_a | input | 5 | Register index of operand A |
| idx_b | input | 5 | Register index of operand B |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| out_valid | output | 1 | Result present |
| illegal | output | 1 | Operation rejected |
| same_reg | output | 1 | Indices equal, results forced to zero |
| res_a | output | 128 | Transposed operand A |
| res_b | output | 128 | Transposed operand B |

## Verification
The checker assumes the inputs are driven to known values while in_valid is high. Because each outgoing value follows from the inputs one cycle earlier, the checker recomputes the flag and zeroing conditions from the registered inputs of the previous cycle. The bench drives inputs only at the falling clock edge, holds them for one cycle, and samples outputs at the next falling edge. Operands carry distinct per-byte patterns so that any misplaced lane changes the result.

// File: rtl/lane_transpose.sv
module lane_transpose #(
  parameter int W = 128,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    size_code,
  input  logic          quad,
  input  logic [IW-1:0] idx_a,
  input  logic [IW-1:0] idx_b,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic          out_valid,
  output logic          illegal,
  output logic          same_reg,
  output logic [W-1:0]  res_a,
  output logic [W-1:0]  res_b
);
  localparam int H = W / 2;

  logic bad, same;
  logic [W-1:0] ta, tb;

  assign bad  = (size_code == 2'b11) || (quad && (idx_a[0] || idx_b[0]));
  assign same = !bad && (idx_a == idx_b);

  function automatic logic [H-1:0] swap_a(input logic [H-1:0] a, input logic [H-1:0] b,
                                          input int lw);
    logic [H-1:0] r;
    r = a;
    for (int p = 0; p < H; p += 2 * lw)
      for (int k = 0; k < lw; k++)
        r[p + lw + k] = b[p + k];
    return r;
  endfunction

  function automatic logic [H-1:0] swap_b(input logic [H-1:0] a, input logic [H-1:0] b,
                                          input int lw);
    logic [H-1:0] r;
    r = b;
    for (int p = 0; p < H; p += 2 * lw)
      for (int k = 0; k < lw; k++)
        r[p + k] = a[p + lw + k];
    return r;
  endfunction

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [H-1:0] a, b, ra, rb;
    assign a = opa[h*H +: H];
    assign b = opb[h*H +: H];
    always_comb begin
      unique case (size_code)
        2'b00:   begin ra = swap_a(a, b, 8);  rb = swap_b(a, b, 8);  end
        2'b01:   begin ra = swap_a(a, b, 16); rb = swap_b(a, b, 16); end
        default: begin ra = swap_a(a, b, 32); rb = swap_b(a, b, 32); end
      endcase
    end
    if (h == 0) begin : g_lo
      assign ta[H-1:0] = ra;
      assign tb[H-1:0] = rb;
    end else begin : g_hi
      assign ta[W-1:H] = quad ? ra : '0;
      assign tb[W-1:H] = quad ? rb : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      same_reg  <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal  <= bad;
        same_reg <= same;
        res_a    <= (bad || same) ? '0 : ta;
        res_b    <= (bad || same) ? '0 : tb;
      end
    end
  end
endmodule

// File: rtl/lane_transpose_chk.sv
module lane_transpose_chk #(
  parameter int W = 128,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    size_code,
  input logic          quad,
  input logic [IW-1:0] idx_a,
  input logic [IW-1:0] idx_b,
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic          out_valid,
  input logic          illegal,
  input logic          same_reg,
  input logic [W-1:0]  res_a,
  input logic [W-1:0]  res_b
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'b11) |=> (illegal && res_a == '0 && res_b == '0)); // R5
  AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quad && (idx_a[0] || idx_b[0])) |=> (illegal && res_a == '0 && res_b == '0)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !quad) |=> (res_a[W-1:W/2] == '0 && res_b[W-1:W/2] == '0)); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && same_reg)); // R9
  AST_SAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    same_reg |-> (res_a == '0 && res_b == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> ($stable(res_a) && $stable(illegal))); // R10
endmodule

bind lane_transpose lane_transpose_chk #(.W(W), .IW(IW)) i_chk (.*);

// File: tb/test_lane_transpose.sv
module test_lane_transpose;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, quad = 0;
  logic [1:0] size_code = 0;
  logic [4:0] idx_a = 0, idx_b = 0;
  logic [127:0] opa = 0, opb = 0;
  logic out_valid, illegal, same_reg;
  logic [127:0] res_a, res_b;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_transpose i_lane_transpose (.*);

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int seed);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(seed * 16 + i);
    return r;
  endfunction

  function automatic void model(input logic [127:0] a, input logic [127:0] b, input int sz,
                                input bit q, output logic [127:0] ea, output logic [127:0] eb);
    int lw = 8 << sz;
    ea = a; eb = b;
    for (int p = 0; p < 128; p += 2 * lw)
      for (int k = 0; k < lw; k++) begin
        ea[p + lw + k] = b[p + k];
        eb[p + k] = a[p + lw + k];
      end
    if (!q) begin ea[127:64] = '0; eb[127:64] = '0; end
  endfunction

  task automatic issue(input int sz, input bit q, input int ia, input int ib,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    in_valid = 1; size_code = 2'(sz); quad = q; idx_a = 5'(ia); idx_b = 5'(ib);
    opa = a; opb = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", 128'(out_valid), 0);
    check("R1 res_a", res_a, 0);
    check("R1 flags", {illegal, same_reg}, 0);
  endtask

  task automatic t_transpose(input int sz, input bit q);
    logic [127:0] ea, eb, a, b;
    a = pat(sz + 1); b = pat(sz + 5);
    model(a, b, sz, q, ea, eb);
    issue(sz, q, 2, 4, a, b);
    check("R2 valid", 128'(out_valid), 1);
    check(q ? "R3/R7 res_a" : "R3/R8 res_a", res_a, ea);
    check("R4 res_b", res_b, eb);
    check("R10 flags", {illegal, same_reg}, 0);
    @(negedge clk);
    check("R2 idle", 128'(out_valid), 0);
  endtask

  task automatic t_illegal(input int sz, input bit q, input int ia, input int ib, input string req);
    issue(sz, q, ia, ib, pat(7), pat(9));
    check({req, " illegal"}, 128'(illegal), 1);
    check({req, " R10 valid"}, 128'(out_valid), 1);
    check({req, " zero"}, res_a | res_b, 0);
    check({req, " R9 no same"}, 128'(same_reg), 0);
  endtask

  task automatic t_same();
    issue(1, 1, 6, 6, pat(3), pat(4));
    check("R9 same_reg", 128'(same_reg), 1);
    check("R9 zero", res_a | res_b, 0);
  endtask

  task automatic t_hold();
    logic [127:0] ea, eb;
    model(pat(2), pat(8), 0, 1, ea, eb);
    issue(0, 1, 0, 2, pat(2), pat(8));
    @(negedge clk);
    opa = pat(11); size_code = 2'b11;
    @(negedge clk);
    check("R10 hold res_a", res_a, ea);
    check("R10 hold illegal", 128'(illegal), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        for (int s = 0; s < 3; s++) begin
          t_transpose(s, 0);
          t_transpose(s, 1);
        end
        t_illegal(3, 0, 2, 4, "R5");
        t_illegal(0, 1, 3, 4, "R6");
        t_illegal(2, 1, 2, 5, "R6");
        t_same();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule